// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block moves outgoing frames from memory to a byte stream. Software builds a chain of 8-byte buffer descriptors in memory, sets the ring base, sets the enable bit and pulses a kick. The engine then walks the chain. For each descriptor it reads the two descriptor words, fetches the data buffer one 32-bit word at a time and hands the bytes out on a valid/ready stream. It then writes the descriptor's first word back with the ready flag cleared and steps to the next descriptor.

Buffers chain into one frame until a descriptor carries the last-in-frame flag. The final byte of the frame carries a last marker. Each consumed descriptor produces single-cycle event pulses that an interrupt controller can latch. A frame that grows past the configured maximum is cut at that size and reported as babble. The walk ends at the first descriptor that is not ready, or after a fixed number of descriptors in one kick, whichever comes first.

Top module: `txbd_ring_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `tx_valid` and `mem_req` are all low.
- R2: A descriptor occupies two words at the descriptor address. The first word holds flags in bits 15:0 and the buffer length in bytes in bits 31:16. The ready flag is bit 15, the wrap flag is bit 13 and the last-in-frame flag is bit 11. The second word holds the byte address of the buffer.
- R3: A kick starts a walk only while `enable` is high. `busy` is high from the cycle after an accepted kick until the walk ends, and it reads low once the walk is over.
- R4: A walk stops at the first descriptor whose ready flag is clear, without consuming it. A walk consumes at most MAX_DESC descriptors, and the next kick resumes where it stopped.
- R5: Buffer bytes go out in address order at any byte alignment, taking the lowest-addressed byte of each word first. Consecutive buffers form one frame until a last-flagged descriptor. `tx_last` is set on the final byte of that frame, including when the last descriptor adds no bytes.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R7: Each consumed descriptor has its first word written back with the ready flag cleared and every other bit, the length included, unchanged.
- R8: After a descriptor with the wrap flag, the next descriptor is read at the ring base. Otherwise the next descriptor is the following 8-byte slot.
- R9: When a buffer would take a frame past MAX_FRAME bytes, only the bytes that fit are sent, and `ev_babble` pulses together with that descriptor's `ev_buf_done`.
- R10: `ev_buf_done` pulses once per consumed descriptor. `ev_frame_done` pulses in the same cycle when that descriptor is last-in-frame. Both pulse only while `busy`.
- R11: A write to the ring base clears its low two bits and, when the engine is idle, also moves the descriptor pointer there. While idle with `enable` low, the pointer is held at the ring base.
- R12: A memory request holds its address and direction until `mem_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable |
| kick | input | 1 | Start-transmit strobe |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | AW | Ring base write value |
| busy | output | 1 | Transmit active |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request completes this cycle |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of frame |
| tx_ready | input | 1 | Stream sink accepts |
| ev_buf_done | output | 1 | Descriptor consumed pulse |
| ev_frame_done | output | 1 | Frame completed pulse |
| ev_babble | output | 1 | Frame truncated pulse |

## Verification
The bench aims at the walk's edges:
- A ring that wraps back to the base inside a single kick. A walker that ignores the wrap bit reads an empty slot and drops the second frame.
- A kick that hits the descriptor cap. A design without the cap consumes all six ready descriptors at once.
- A frame that crosses the size limit. A design that gets this wrong either sends 50 bytes or stays silent on babble.
- A zero-length closing descriptor. A naive streamer would never mark a final byte there.

It also covers buffers at odd byte offsets, the pointer reset on disable, and a base written with its low bits set; the last would fetch from a misaligned address if the bits were kept. Stalls on both the memory port and the stream run throughout.

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine #(
  parameter int AW         = 32,
  parameter int MAX_FRAME  = 2047,
  parameter int MAX_DESC   = 1024,
  parameter int READY_BIT  = 15,
  parameter int WRAP_BIT   = 13,
  parameter int LAST_BIT   = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          kick,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ready,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic          ev_buf_done,
  output logic          ev_frame_done,
  output logic          ev_babble
);
  localparam int FCW = $clog2(MAX_FRAME + 1);
  localparam int DCW = $clog2(MAX_DESC + 1);

  typedef enum logic [2:0] {S_IDLE, S_W0, S_W1, S_WORD, S_EMIT, S_END, S_WB} st_t;

  st_t           state;
  logic [AW-1:0] base, ptr, bp;
  logic [15:0]   flags, len, rem;
  logic [31:0]   word;
  logic [FCW-1:0] fcnt;
  logic [DCW-1:0] dcnt;
  logic          cut;
  logic          h_valid;
  logic [7:0]    h_data;

  logic [15:0]   new_len, room, eff, wb_flags;
  logic          over, out_free, emit_go, end_go, wb_done, is_last;
  logic [7:0]    cur_byte;

  assign new_len  = mem_rdata[31:16];
  assign room     = 16'(MAX_FRAME) - 16'(fcnt);
  assign over     = new_len > room;
  assign eff      = over ? room : new_len;
  assign is_last  = flags[LAST_BIT];
  assign out_free = !tx_valid || tx_ready;
  assign cur_byte = word[{bp[1:0], 3'b000} +: 8];
  assign emit_go  = (state == S_EMIT) && (!h_valid || out_free);
  assign end_go   = (state == S_END) && (!(is_last && h_valid) || out_free);
  assign wb_done  = (state == S_WB) && mem_ready;

  assign busy          = state != S_IDLE;
  assign mem_req       = state inside {S_W0, S_W1, S_WORD, S_WB};
  assign mem_we        = state == S_WB;
  assign ev_buf_done   = wb_done;
  assign ev_frame_done = wb_done && is_last;
  assign ev_babble     = wb_done && cut;

  always_comb begin
    wb_flags = flags;
    wb_flags[READY_BIT] = 1'b0;
  end
  assign mem_wdata = {len, wb_flags};

  always_comb begin
    case (state)
      S_W1:    mem_addr = ptr + AW'(4);
      S_WORD:  mem_addr = {bp[AW-1:2], 2'b00};
      default: mem_addr = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) base <= '0;
    else if (base_wr) base <= base_wdata & ~AW'(3);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
      h_valid  <= 1'b0;
      h_data   <= '0;
    end else begin
      if ((emit_go || (end_go && is_last)) && h_valid) begin
        tx_valid <= 1'b1;
        tx_data  <= h_data;
        tx_last  <= end_go;
      end else if (tx_ready) begin
        tx_valid <= 1'b0;
      end
      if (emit_go) begin
        h_valid <= 1'b1;
        h_data  <= cur_byte;
      end else if (end_go && is_last) begin
        h_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr   <= '0;
      bp    <= '0;
      flags <= '0;
      len   <= '0;
      rem   <= '0;
      word  <= '0;
      fcnt  <= '0;
      dcnt  <= '0;
      cut   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (base_wr) ptr <= base_wdata & ~AW'(3);
          else if (!enable) ptr <= base;
          if (kick && enable) begin
            dcnt  <= '0;
            state <= S_W0;
          end
        end
        S_W0: if (mem_ready) begin
          flags <= mem_rdata[15:0];
          len   <= new_len;
          rem   <= eff;
          cut   <= over;
          state <= mem_rdata[READY_BIT] ? S_W1 : S_IDLE;
        end
        S_W1: if (mem_ready) begin
          bp    <= mem_rdata[AW-1:0];
          state <= (rem == 16'd0) ? S_END : S_WORD;
        end
        S_WORD: if (mem_ready) begin
          word  <= mem_rdata;
          state <= S_EMIT;
        end
        S_EMIT: if (emit_go) begin
          bp   <= bp + AW'(1);
          rem  <= rem - 16'd1;
          fcnt <= fcnt + FCW'(1);
          if (rem == 16'd1) state <= S_END;
          else if (bp[1:0] == 2'd3) state <= S_WORD;
        end
        S_END: if (end_go) begin
          if (is_last) fcnt <= '0;
          state <= S_WB;
        end
        S_WB: if (mem_ready) begin
          ptr   <= flags[WRAP_BIT] ? base : ptr + AW'(8);
          dcnt  <= dcnt + DCW'(1);
          state <= (dcnt + DCW'(1) == DCW'(MAX_DESC)) ? S_IDLE : S_W0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txbd_ring_engine_chk.sv
module txbd_ring_engine_chk #(
  parameter int AW        = 32,
  parameter int MAX_DESC  = 1024,
  parameter int READY_BIT = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          kick,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ready,
  input logic [7:0]    tx_data,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          ev_buf_done,
  input logic          ev_frame_done,
  input logic          ev_babble
);
  int unsigned walk_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) walk_cnt <= 0;
    else if (ev_buf_done) walk_cnt <= walk_cnt + 1;
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  assert_req_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_wb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[READY_BIT]);

  assert_frame_buf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |-> ev_buf_done);

  assert_evt_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_buf_done |-> busy);

  assert_babble_buf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_babble |-> ev_buf_done);

  assert_no_kick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !enable && !busy) |=> !busy);

  assert_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cnt <= MAX_DESC);
endmodule

bind txbd_ring_engine txbd_ring_engine_chk #(
  .AW(AW), .MAX_DESC(MAX_DESC), .READY_BIT(READY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready), .tx_data(tx_data),
  .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
  .ev_buf_done(ev_buf_done), .ev_frame_done(ev_frame_done),
  .ev_babble(ev_babble)
);

// File: tb/txbd_ring_engine_test.sv
`timescale 1ns/1ps
module txbd_ring_engine_test;
  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, LST = 16'h0800;

  logic clk = 0, rst_n = 0, enable = 0, kick = 0, base_wr = 0;
  logic [31:0] base_wdata = 0;
  logic busy, mem_req, mem_we, mem_ready, tx_valid, tx_last, tx_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] tx_data;
  logic ev_buf_done, ev_frame_done, ev_babble;

  logic [31:0] mem [0:511];
  logic hw_en = 0;
  logic [8:0] hw_idx = 0;
  logic [31:0] hw_data = 0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int cnt_buf = 0, cnt_frm = 0, cnt_bab = 0;
  logic [8:0] expq [$];
  logic stall_seen = 0;
  logic [31:0] stall_addr = 0;

  always #10 clk = ~clk;

  txbd_ring_engine #(.MAX_FRAME(40), .MAX_DESC(4)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .kick(kick),
    .base_wr(base_wr), .base_wdata(base_wdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_ready(tx_ready), .ev_buf_done(ev_buf_done),
    .ev_frame_done(ev_frame_done), .ev_babble(ev_babble));

  assign mem_rdata = (mem_addr[1:0] != 2'b00) ? 32'h0 : mem[mem_addr[10:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mem[i]) mem[i] <= 32'h0;
    end else if (hw_en) begin
      mem[hw_idx] <= hw_data;
    end else if (mem_req && mem_we && mem_ready && mem_addr[1:0] == 2'b00) begin
      mem[mem_addr[10:2]] <= mem_wdata;
    end
  end

  initial begin
    tx_ready = 1'b1;
    mem_ready = 1'b1;
  end
  always @(negedge clk) begin
    cyc++;
    tx_ready  = (cyc % 5) != 3;
    mem_ready = (cyc % 7) != 2;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      if (ev_buf_done) cnt_buf++;
      if (ev_frame_done) cnt_frm++;
      if (ev_babble) cnt_bab++;
      if (stall_seen) chk(mem_req && mem_addr == stall_addr, "R12 request held", mem_addr, stall_addr);
      stall_seen = mem_req && !mem_ready;
      stall_addr = mem_addr;
      if (tx_valid && tx_ready) begin
        if (expq.size() == 0) chk(0, "R5 unexpected byte", {23'd0, tx_last, tx_data}, 32'h0);
        else begin
          logic [8:0] e;
          e = expq.pop_front();
          chk({tx_last, tx_data} == e, "R5/R6 stream byte", {23'd0, tx_last, tx_data}, {23'd0, e});
        end
      end
    end
  end

  task automatic wr_word(input int addr, input logic [31:0] v);
    @(negedge clk);
    hw_en = 1; hw_idx = addr[10:2]; hw_data = v;
    @(negedge clk);
    hw_en = 0;
  endtask

  task automatic set_desc(input int idx, input logic [15:0] fl, input logic [15:0] ln, input int bufa);
    wr_word(idx * 8, {ln, fl});
    wr_word(idx * 8 + 4, bufa);
  endtask

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic fill(input int addr, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      int a;
      logic [31:0] w;
      a = addr + i;
      w = mem[a[10:2]];
      w[8 * (a % 4) +: 8] = pat(seed, i);
      wr_word(a & ~3, w);
    end
  endtask

  task automatic push_exp(input logic [7:0] seed, input int n, input bit last);
    for (int i = 0; i < n; i++) expq.push_back({last && (i == n - 1), pat(seed, i)});
  endtask

  task automatic write_base(input logic [31:0] v);
    @(negedge clk); base_wr = 1; base_wdata = v;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic kick_run(input string tag);
    int t;
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    chk(busy == 1'b1, {tag, " R3 busy after kick"}, busy, 1);
    t = 0;
    while (busy && t < 3000) begin @(negedge clk); t++; end
    while ((expq.size() != 0 || tx_valid) && t < 3000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, {tag, " R3 idle after walk"}, busy, 0);
    chk(expq.size() == 0, {tag, " R5 all bytes sent"}, expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int b0, f0, k0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !tx_valid && !mem_req, "R1 reset idle", {busy, tx_valid, mem_req}, 0);

    // single descriptor frame
    enable = 1;
    write_base(32'h0);
    set_desc(0, RDY | LST, 16'd5, 32'h200);
    fill(32'h200, 5, 8'h10); push_exp(8'h10, 5, 1);
    b0 = cnt_buf; f0 = cnt_frm; k0 = cnt_bab;
    kick_run("T2");
    chk(cnt_buf == b0 + 1 && cnt_frm == f0 + 1, "R10 one buf one frame", cnt_buf - b0, 1);
    chk(cnt_bab == k0, "R9 no babble", cnt_bab - k0, 0);
    chk(mem[0] == {16'd5, LST}, "R7 R2 writeback word", mem[0], {16'd5, LST});

    // three buffers at odd offsets, stop at empty slot
    set_desc(1, RDY, 16'd3, 32'h301);
    set_desc(2, RDY, 16'd6, 32'h312);
    set_desc(3, RDY | LST, 16'd2, 32'h320);
    fill(32'h301, 3, 8'h21); fill(32'h312, 6, 8'h33); fill(32'h320, 2, 8'h45);
    push_exp(8'h21, 3, 0); push_exp(8'h33, 6, 0); push_exp(8'h45, 2, 1);
    b0 = cnt_buf; f0 = cnt_frm;
    kick_run("T3");
    chk(cnt_buf == b0 + 3, "R4 stop at not-ready", cnt_buf - b0, 3);
    chk(cnt_frm == f0 + 1, "R10 gathered frame", cnt_frm - f0, 1);

    // wrap inside one kick
    set_desc(4, RDY | LST | WRP, 16'd4, 32'h340);
    set_desc(0, RDY | LST, 16'd2, 32'h350);
    fill(32'h340, 4, 8'h50); fill(32'h350, 2, 8'h60);
    push_exp(8'h50, 4, 1); push_exp(8'h60, 2, 1);
    b0 = cnt_buf; f0 = cnt_frm;
    kick_run("T5");
    chk(cnt_buf == b0 + 2 && cnt_frm == f0 + 2, "R8 wrap to base", cnt_buf - b0, 2);
    chk(mem[8] == {16'd4, LST | WRP}, "R7 wrap desc writeback", mem[8], {16'd4, LST | WRP});

    // descriptor cap per kick
    for (int i = 1; i <= 6; i++) begin
      set_desc(i, RDY | LST, 16'd1, 32'h360 + i);
      fill(32'h360 + i, 1, 8'h70 + 8'(i));
    end
    for (int i = 1; i <= 4; i++) push_exp(8'h70 + 8'(i), 1, 1);
    b0 = cnt_buf;
    kick_run("T6a");
    chk(cnt_buf == b0 + 4, "R4 cap per kick", cnt_buf - b0, 4);
    for (int i = 5; i <= 6; i++) push_exp(8'h70 + 8'(i), 1, 1);
    b0 = cnt_buf;
    kick_run("T6b");
    chk(cnt_buf == b0 + 2, "R4 resume after cap", cnt_buf - b0, 2);

    // babble truncation at 40 bytes
    set_desc(7, RDY, 16'd30, 32'h400);
    set_desc(8, RDY | LST, 16'd20, 32'h420);
    fill(32'h400, 30, 8'h80); fill(32'h420, 20, 8'h90);
    push_exp(8'h80, 30, 0); push_exp(8'h90, 10, 1);
    b0 = cnt_buf; f0 = cnt_frm; k0 = cnt_bab;
    kick_run("T7");
    chk(cnt_bab == k0 + 1, "R9 babble flagged", cnt_bab - k0, 1);
    chk(cnt_buf == b0 + 2 && cnt_frm == f0 + 1, "R10 babble frame events", cnt_buf - b0, 2);
    chk(mem[16] == {16'd20, LST}, "R9 length kept on writeback", mem[16], {16'd20, LST});

    // zero-length closing descriptor
    set_desc(9, RDY, 16'd3, 32'h440);
    set_desc(10, RDY | LST, 16'd0, 32'h0);
    fill(32'h440, 3, 8'hA0); push_exp(8'hA0, 3, 1);
    f0 = cnt_frm;
    kick_run("T8");
    chk(cnt_frm == f0 + 1, "R5 zero-length last", cnt_frm - f0, 1);

    // kick ignored while disabled
    enable = 0;
    set_desc(0, RDY | LST, 16'd2, 32'h460);
    fill(32'h460, 2, 8'hB0);
    b0 = cnt_buf;
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    repeat (20) @(negedge clk);
    chk(!busy && cnt_buf == b0, "R3 kick while disabled", cnt_buf - b0, 0);
    chk(mem[0][15] == 1'b1, "R3 descriptor untouched", mem[0], {16'd2, RDY | LST});

    // disable returned pointer to base
    enable = 1;
    push_exp(8'hB0, 2, 1);
    b0 = cnt_buf;
    kick_run("T10");
    chk(cnt_buf == b0 + 1 && mem[0] == {16'd2, LST}, "R11 pointer back at base", mem[0], {16'd2, LST});

    // base low bits dropped
    write_base(32'h0A3);
    set_desc(20, RDY | LST, 16'd3, 32'h470);
    fill(32'h470, 3, 8'hC0); push_exp(8'hC0, 3, 1);
    b0 = cnt_buf;
    kick_run("T11");
    chk(cnt_buf == b0 + 1, "R11 aligned base", cnt_buf - b0, 1);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule